// File: doc/BRIEF.md
# Registered One-Hot AND-OR Selector

This block picks one of N data words with an N-bit enable vector. It builds no priority chain to do so. Each word is gated by its own enable bit, and the gated words are merged by a wide OR. The merged value goes through one register, which is the selector output. That register loads only in cycles where at least one enable is active. When every enable is low, it keeps its last value, so a consumer can drop the enables between transfers without losing the word.

The unregistered AND-OR value is also brought out for logic that needs it in the same cycle. A parameter chooses how the register stage is built:

- **Shared register:** one output register after the OR tree.
- **Per-source registers:** one register per source, each loaded with its gated word, followed by the OR tree.

Both builds behave the same at the ports. A built-in guard watches the enable vector. In the cycle after it samples a vector with two or more bits set, it raises a registered error flag.

Top module: `onehot_sel_mux`

## Requirements
- R1: In the cycle after a rising clock edge that samples `en_i` with exactly bit k set, `data_o` equals data word k.
- R2: Word k occupies bits [k*W +: W] of `data_i`, with word 0 in the least significant bits.
- R3: When several enable bits are sampled together, `data_o` becomes the bitwise OR of all enabled words. No lower or higher index takes precedence.
- R4: A rising edge that samples `en_i` equal to zero leaves `data_o` unchanged.
- R5: `comb_o` is the bitwise OR of the enabled words in the current inputs, with no clock delay. It is zero when `en_i` is zero.
- R6: `multi_err_o` is 1 in the cycle after an edge that samples two or more enable bits set. It is 0 after an edge that samples zero or one bit set.
- R7: While `rst_ni` is low, `data_o` and `multi_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N*W | N packed data words, word k at [k*W +: W] |
| en_i | input | N | Enable vector, one bit per word |
| data_o | output | W | Registered selected word |
| comb_o | output | W | Unregistered AND-OR of the enabled words |
| multi_err_o | output | 1 | Registered flag for an enable vector with more than one bit set |

## Verification
The embedded properties check several rules on every cycle:
- the output holds across idle cycles;
- a one-hot load matches the AND-OR value of the previous cycle;
- the combinational path is zero when no enable is set;
- the error flag follows the population count of the sampled enables.

Other behaviours can only be shown by the scoreboard scenarios, because they need a reference model of the data:
- the word-to-lane mapping;
- the OR merge of 00010111;
- the values held across long idle runs;
- the reset values.

// File: rtl/onehot_sel_pkg.sv
package onehot_sel_pkg;
  typedef enum logic {
    ARCH_SHARED_REG  = 1'b0,
    ARCH_PER_SRC_REG = 1'b1
  } sel_arch_e;
endpackage

// File: rtl/andor_reduce.sv
module andor_reduce #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N*W-1:0] data_i,
  input  logic [N-1:0]   en_i,
  output logic [W-1:0]   out_o
);
  logic [W-1:0] masked [N];

  for (genvar i = 0; i < N; i++) begin : g_mask
    assign masked[i] = data_i[i*W +: W] & {W{en_i[i]}};
  end

  always_comb begin
    out_o = '0;
    for (int i = 0; i < N; i++) out_o = out_o | masked[i];
  end
endmodule

// File: rtl/multihot_detect.sv
module multihot_detect #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  output logic         err_o
);
  localparam logic [N-1:0] One = {{(N-1){1'b0}}, 1'b1};

  logic multi;
  // clearing the lowest set bit leaves a residue only with 2+ bits
  assign multi = |(en_i & (en_i - One));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= multi;
  end

  // R6
  multi_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(en_i) > 1) |=> err_o);

  // R6
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_i) |=> !err_o);
endmodule

// File: rtl/onehot_sel_mux.sv
module onehot_sel_mux
  import onehot_sel_pkg::*;
#(
  parameter int        N    = 8,
  parameter int        W    = 16,
  parameter sel_arch_e ARCH = ARCH_SHARED_REG
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N*W-1:0] data_i,
  input  logic [N-1:0]   en_i,
  output logic [W-1:0]   data_o,
  output logic [W-1:0]   comb_o,
  output logic           multi_err_o
);
  logic any_en;
  assign any_en = |en_i;

  andor_reduce #(.N(N), .W(W)) u_mux (
    .data_i (data_i),
    .en_i   (en_i),
    .out_o  (comb_o)
  );

  if (ARCH == ARCH_SHARED_REG) begin : g_shared
    logic [W-1:0] data_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_q <= '0;
      else if (any_en) data_q <= comb_o;
    end
    assign data_o = data_q;
  end else begin : g_per_src
    logic [N*W-1:0] src_q;
    for (genvar i = 0; i < N; i++) begin : g_src
      // unselected sources are cleared, so the OR sees only enabled words
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     src_q[i*W +: W] <= '0;
        else if (any_en) src_q[i*W +: W] <= en_i[i] ? data_i[i*W +: W] : '0;
      end
    end
    andor_reduce #(.N(N), .W(W)) u_or (
      .data_i (src_q),
      .en_i   ({N{1'b1}}),
      .out_o  (data_o)
    );
  end

  multihot_detect #(.N(N)) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .err_o  (multi_err_o)
  );

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> $stable(data_o));

  // R1
  onehot_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(en_i) |=> (data_o == $past(comb_o)));

  // R5
  comb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (comb_o == '0));
endmodule

// File: tb/onehot_sel_mux_test.sv
module onehot_sel_mux_test;
  localparam int N = 8;
  localparam int W = 16;
  localparam time CLK = 20ns;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N*W-1:0] data_i = '0;
  logic [N-1:0]   en_i = '0;
  logic [W-1:0]   data_o, comb_o;
  logic           multi_err_o;

  onehot_sel_mux #(.N(N), .W(W)) uut (
    .clk_i, .rst_ni, .data_i, .en_i, .data_o, .comb_o, .multi_err_o
  );

  always #(CLK/2) clk_i = ~clk_i;

  typedef struct {
    logic [W-1:0] d;
    logic         e;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] words [N];
  logic [W-1:0] model = '0;
  int           total = 0;
  int           fails = 0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2: word k is driven on lanes [k*W +: W]
  task automatic drive(input logic [N-1:0] en, input string tag);
    logic [W-1:0] ec;
    exp_t it;
    @(negedge clk_i);
    for (int k = 0; k < N; k++) data_i[k*W +: W] = words[k];
    en_i = en;
    #1;
    ec = '0;
    for (int k = 0; k < N; k++) if (en[k]) ec = ec | words[k];
    check(comb_o == ec, "R5 comb", comb_o, ec);
    if (en != '0) model = ec;
    it.d = model;
    it.e = ($countones(en) > 1);
    it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(data_o == it.d, it.tag, data_o, it.d);
        check(multi_err_o == it.e, "R6 err", W'(multi_err_o), W'(it.e));
      end
    end
  end

  initial begin : watchdog
    #(CLK * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    for (int k = 0; k < N; k++) words[k] = W'(16'h1111 * (k + 1)) ^ W'(k << 12);
    repeat (3) @(negedge clk_i);
    check(data_o == '0, "R7 reset data", data_o, '0);
    check(multi_err_o == 1'b0, "R7 reset err", W'(multi_err_o), '0);
    rst_ni = 1'b1;

    // R5: zero enable, comb output zero
    drive('0, "R4 idle after reset");
    // R1 / R2: each lane alone
    for (int k = 0; k < N; k++) drive(N'(1) << k, "R1 onehot");
    drive('0, "R4 hold");
    drive('0, "R4 hold");
    // R3: multi-hot ORs, no priority
    drive(8'b0001_0111, "R3 multi");
    drive('0, "R4 hold after multi");
    drive(8'b1000_0001, "R3 ends");
    drive(8'b1000_0000, "R1 top");
    // distinct word pattern, then single bits again
    for (int k = 0; k < N; k++) words[k] = ~words[k];
    drive(8'b0000_0100, "R1 inverted");
    drive(8'hFF, "R3 all");
    drive('0, "R4 hold all");
    for (int c = 0; c < 40; c++) begin
      for (int k = 0; k < N; k++) words[k] = W'($urandom);
      case ($urandom % 3)
        0:       drive('0, "R4 rand idle");
        1:       drive(N'(1) << ($urandom % N), "R1 rand onehot");
        default: drive(N'($urandom), "R3 rand any");
      endcase
    end
    drive('0, "R4 final");
    @(negedge clk_i);
    @(negedge clk_i);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule